// File: doc/BRIEF.md
# Multi-Channel Input Capture Unit

This block timestamps edges on a set of input pins. Each channel passes its pin through a two-flop synchronizer and then a stability filter. It then picks the edge polarity it cares about and divides the stream of qualifying edges by a power of two. At the chosen edge it copies one of two shared free-running timer values into a private two-entry FIFO. The timers themselves are generated elsewhere and arrive as plain input buses.

Software sees one read port. It selects a channel, observes the oldest stored timestamp of that channel, and removes it with a one-cycle pop strobe. Each channel reports whether it holds data, raises a maskable interrupt request while it does, and keeps a sticky flag when a timestamp had to be dropped because its FIFO was full.

Top module: `icap_bank`

## Requirements
- R1: After reset every channel is empty, `not_empty`, `cap_ovf` and `irq` are all 0, and `rd_data` reads 0.
- R2: The 2-bit edge field of channel c (`edge_sel[2c+1:2c]`) selects 0 = capture disabled, 1 = rising edges, 2 = falling edges, 3 = both edges of the filtered input.
- R3: A capture on channel c stores `tmr_a` when `tsel[c]` is 0 and `tmr_b` when it is 1, taken in the cycle the filtered edge is accepted.
- R4: The filtered level takes a new value only after the synchronized pin has differed from it for max(N,1) consecutive clocks, where N is the 4-bit field `flt_n[4c+3:4c]`. Shorter pulses cause no capture.
- R5: The 2-bit divide field `div_sel[2c+1:2c]` with code d makes a capture on every K-th qualifying edge, K = 2^d (1, 2, 4, 8), the first on the K-th edge. The edge counter restarts from zero while the channel's edge field is 0.
- R6: Each channel buffers up to two timestamps, oldest first. `rd_data` shows the oldest entry of channel `rd_ch`, or 0 if that channel is empty. A cycle with `rd_en` high removes that entry, and popping an empty channel changes nothing.
- R7: A capture into a full FIFO with no pop of that channel in the same cycle is discarded and sets `cap_ovf[c]`. The flag stays set until the next pop of that channel.
- R8: `not_empty[c]` is 1 exactly while channel c holds data, and `irq[c]` equals `not_empty[c]` gated by `irq_en[c]`. Activity on one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | NCH | Raw capture pins, one per channel |
| tmr_a | input | TW | First shared time base |
| tmr_b | input | TW | Second shared time base |
| edge_sel | input | 2*NCH | Edge mode per channel |
| div_sel | input | 2*NCH | Edge divide code per channel |
| flt_n | input | FW*NCH | Filter length per channel |
| tsel | input | NCH | Time-base select per channel |
| irq_en | input | NCH | Interrupt enable per channel |
| rd_en | input | 1 | Pop strobe for channel `rd_ch` |
| rd_ch | input | CW | Channel selected for reading |
| rd_data | output | TW | Oldest timestamp of the selected channel |
| not_empty | output | NCH | Channel holds data |
| cap_ovf | output | NCH | Sticky dropped-capture flag |
| irq | output | NCH | Interrupt request per channel |

## Verification
A table of pulse trains varies the edge mode, the divide code, the filter length and the time-base select one channel at a time. Each row tells whether the edge counting, the division and the timer choice agree on the number of stored entries and their value. A row with more captures than slots separates correct overflow discarding from overwriting, and a disabled-mode row separates gating from counting. Directed runs use a pulse just shorter than the filter length against one just longer, and a single-cycle pulse with a zero length. They also use two different timestamps to tell ordering apart, a divide sequence interrupted by disabling to show the counter restart, and an interrupt mask toggled while data sits in a neighbouring channel.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_mode_e;

  // An accepted level change counts as an edge of interest for this mode.
  function automatic logic edge_wanted(input edge_mode_e mode, input logic new_lvl);
    case (mode)
      EDG_RISE: return new_lvl;
      EDG_FALL: return !new_lvl;
      EDG_BOTH: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  // Last count value of the edge divider: K-1 with K = 2^code.
  function automatic logic [2:0] div_last(input logic [1:0] code);
    return 3'((4'd1 << code) - 4'd1);
  endfunction

  // True when the current run of differing samples completes the filter window.
  function automatic logic run_settled(input logic [7:0] run, input logic [7:0] len);
    logic [8:0] need;
    need = (len == 8'd0) ? 9'd1 : {1'b0, len};
    return ({1'b0, run} + 9'd1) >= need;
  endfunction

endpackage

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [FW-1:0] len,
  output logic          sync_lvl,
  output logic          lvl,
  output logic          upd
);
  import icap_pkg::*;

  logic          s1;
  logic [FW-1:0] run;
  logic          differs;

  assign differs = (sync_lvl != lvl);
  assign upd     = differs && run_settled(8'(run), 8'(len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      sync_lvl <= 1'b0;
      lvl      <= 1'b0;
      run      <= '0;
    end else begin
      s1       <= pin;
      sync_lvl <= s1;
      if (upd) begin
        lvl <= sync_lvl;
        run <= '0;
      end else if (differs) begin
        run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/icap_divider.sv
module icap_divider (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] code,
  input  logic       upd,
  input  logic       new_lvl,
  output logic       cap
);
  import icap_pkg::*;

  logic [2:0] cnt;
  logic       qual;
  logic       at_last;

  assign qual    = upd && edge_wanted(edge_mode_e'(mode), new_lvl);
  assign at_last = (cnt == div_last(code));
  assign cap     = qual && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (edge_mode_e'(mode) == EDG_OFF) begin
      cnt <= '0;
    end else if (qual) begin
      cnt <= at_last ? 3'd0 : cnt + 3'd1;
    end
  end
endmodule

// File: rtl/icap_fifo2.sv
module icap_fifo2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         ne,
  output logic         full,
  output logic         ovf
);
  logic [W-1:0] e0, e1;
  logic [1:0]   cnt, wpos;
  logic         pop_ok, wr_ok;

  assign ne     = (cnt != 2'd0);
  assign full   = (cnt == 2'd2);
  assign pop_ok = pop && ne;
  assign wr_ok  = wr && (!full || pop_ok);
  assign wpos   = cnt - {1'b0, pop_ok};
  assign head   = e0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      e0  <= '0;
      e1  <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt - {1'b0, pop_ok} + {1'b0, wr_ok};
      if (pop_ok) e0 <= e1;
      if (wr_ok) begin
        if (wpos == 2'd0) e0 <= wdata;
        else              e1 <= wdata;
      end
      if (wr && !wr_ok)  ovf <= 1'b1;
      else if (pop_ok)   ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_bank.sv
module icap_bank #(
  parameter int NCH = 4,
  parameter int TW  = 16,
  parameter int FW  = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_in,
  input  logic [TW-1:0]     tmr_a,
  input  logic [TW-1:0]     tmr_b,
  input  logic [2*NCH-1:0]  edge_sel,
  input  logic [2*NCH-1:0]  div_sel,
  input  logic [FW*NCH-1:0] flt_n,
  input  logic [NCH-1:0]    tsel,
  input  logic [NCH-1:0]    irq_en,
  input  logic              rd_en,
  input  logic [CW-1:0]     rd_ch,
  output logic [TW-1:0]     rd_data,
  output logic [NCH-1:0]    not_empty,
  output logic [NCH-1:0]    cap_ovf,
  output logic [NCH-1:0]    irq
);
  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] sync_lvl;
  logic [NCH-1:0] flt_lvl;
  logic [NCH-1:0] flt_upd;
  logic [NCH-1:0] cap_stb;
  logic [NCH-1:0] fifo_full;
  logic [NCH-1:0] pop_ch;
  logic [TW-1:0]  head [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TW-1:0] stamp;
    assign stamp     = tsel[c] ? tmr_b : tmr_a;
    assign pop_ch[c] = rd_en && (int'(rd_ch) == c);

    icap_filter #(.FW(FW)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_in[c]),
      .len      (flt_n[FW*c +: FW]),
      .sync_lvl (sync_lvl[c]),
      .lvl      (flt_lvl[c]),
      .upd      (flt_upd[c])
    );

    icap_divider u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (edge_sel[2*c +: 2]),
      .code    (div_sel[2*c +: 2]),
      .upd     (flt_upd[c]),
      .new_lvl (sync_lvl[c]),
      .cap     (cap_stb[c])
    );

    icap_fifo2 #(.W(TW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cap_stb[c]),
      .wdata (stamp),
      .pop   (pop_ch[c]),
      .head  (head[c]),
      .ne    (not_empty[c]),
      .full  (fifo_full[c]),
      .ovf   (cap_ovf[c])
    );
  end

  assign irq = not_empty & irq_en;

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if ((int'(rd_ch) == c) && not_empty[c]) rd_data = head[c];
    end
  end
endmodule

// File: rtl/icap_bank_chk.sv
module icap_bank_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   cap_stb,
  input logic [NCH-1:0]   fifo_full,
  input logic [NCH-1:0]   pop_ch,
  input logic [NCH-1:0]   not_empty,
  input logic [NCH-1:0]   cap_ovf,
  input logic [2*NCH-1:0] edge_sel,
  input logic [NCH-1:0]   sync_lvl,
  input logic [NCH-1:0]   flt_lvl
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_ovf_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb[c] && fifo_full[c] && !pop_ch[c] |=> cap_ovf[c]);

    assert_ovf_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ch[c] && !cap_stb[c] |=> !cap_ovf[c]);

    assert_capture_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb[c] |=> not_empty[c]);

    assert_off_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel[2*c +: 2] == 2'd0 |-> !cap_stb[c]);

    assert_filter_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flt_lvl[c] != $past(flt_lvl[c]) |-> flt_lvl[c] == $past(sync_lvl[c]));
  end
endmodule

bind icap_bank icap_bank_chk #(.NCH(NCH)) u_icap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_stb   (cap_stb),
  .fifo_full (fifo_full),
  .pop_ch    (pop_ch),
  .not_empty (not_empty),
  .cap_ovf   (cap_ovf),
  .edge_sel  (edge_sel),
  .sync_lvl  (sync_lvl),
  .flt_lvl   (flt_lvl)
);

// File: tb/test_icap_bank.sv
`timescale 1ns/1ps
module test_icap_bank;
  localparam int NCH = 4;
  localparam int TW  = 16;
  localparam int FW  = 4;
  localparam int CW  = 2;

  // {ch[17:16], edge[15:14], div[13:12], flt[11:8], tsel[7], pulses[6:3], entries[2:1], ovf[0]}
  localparam logic [17:0] VEC [9] = '{
    {2'd0, 2'd1, 2'd0, 4'd1, 1'b0, 4'd1, 2'd1, 1'b0},
    {2'd1, 2'd2, 2'd0, 4'd2, 1'b1, 4'd2, 2'd2, 1'b0},
    {2'd2, 2'd3, 2'd1, 4'd3, 1'b0, 4'd2, 2'd2, 1'b0},
    {2'd3, 2'd1, 2'd2, 4'd4, 1'b1, 4'd5, 2'd1, 1'b0},
    {2'd0, 2'd3, 2'd0, 4'd0, 1'b1, 4'd2, 2'd2, 1'b1},
    {2'd1, 2'd0, 2'd0, 4'd1, 1'b0, 4'd3, 2'd0, 1'b0},
    {2'd2, 2'd3, 2'd3, 4'd1, 1'b1, 4'd4, 2'd1, 1'b0},
    {2'd3, 2'd2, 2'd1, 4'd1, 1'b0, 4'd3, 2'd1, 1'b0},
    {2'd0, 2'd1, 2'd3, 4'd2, 1'b0, 4'd7, 2'd0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    cap_in;
  logic [TW-1:0]     tmr_a, tmr_b;
  logic [2*NCH-1:0]  edge_sel, div_sel;
  logic [FW*NCH-1:0] flt_n;
  logic [NCH-1:0]    tsel, irq_en;
  logic              rd_en;
  logic [CW-1:0]     rd_ch;
  logic [TW-1:0]     rd_data;
  logic [NCH-1:0]    not_empty, cap_ovf, irq;

  int checks = 0;
  int bad    = 0;

  always #2.5 clk = ~clk;

  icap_bank #(.NCH(NCH), .TW(TW), .FW(FW)) i_icap_bank (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .edge_sel(edge_sel), .div_sel(div_sel), .flt_n(flt_n), .tsel(tsel),
    .irq_en(irq_en), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
    .not_empty(not_empty), .cap_ovf(cap_ovf), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int hi, input int lo);
    cap_in[ch] = 1'b1;
    tick(hi);
    cap_in[ch] = 1'b0;
    tick(lo);
  endtask

  task automatic pop_one(input int ch, output logic [TW-1:0] v);
    rd_ch = CW'(ch);
    rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain(input int ch);
    logic [TW-1:0] v;
    for (int k = 0; k < 4; k++) if (not_empty[ch]) pop_one(ch, v);
  endtask

  task automatic set_cfg(input int ch, input int md, input int dv, input int fl,
                         input bit ts);
    edge_sel[2*ch +: 2] = 2'd0;
    tick(1);
    edge_sel[2*ch +: 2] = 2'(md);
    div_sel[2*ch +: 2]  = 2'(dv);
    flt_n[FW*ch +: FW]  = FW'(fl);
    tsel[ch]            = ts;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] v, expv;
    int n;
    rst_n    = 1'b0;
    cap_in   = '0;
    tmr_a    = '0;
    tmr_b    = '0;
    edge_sel = '0;
    div_sel  = '0;
    flt_n    = {NCH{4'd1}};
    tsel     = '0;
    irq_en   = '1;
    rd_en    = 1'b0;
    rd_ch    = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    check(not_empty == 0, "R1 not_empty", 32'(not_empty), 0);
    check(cap_ovf == 0, "R1 cap_ovf", 32'(cap_ovf), 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
    check(rd_data == 0, "R1 rd_data", 32'(rd_data), 0);

    // Table of vectors: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 9; i++) begin
      int ch, md, dv, fl, pn, exn;
      bit ts, exo;
      ch  = int'(VEC[i][17:16]);
      md  = int'(VEC[i][15:14]);
      dv  = int'(VEC[i][13:12]);
      fl  = int'(VEC[i][11:8]);
      ts  = VEC[i][7];
      pn  = int'(VEC[i][6:3]);
      exn = int'(VEC[i][2:1]);
      exo = VEC[i][0];
      drain(ch);
      tmr_a = 16'hA000 + 16'(i);
      tmr_b = 16'h5B00 + 16'(i);
      expv  = ts ? tmr_b : tmr_a;
      set_cfg(ch, md, dv, fl, ts);
      for (int p = 0; p < pn; p++) pulse(ch, 8, 8);
      tick(6);
      check(cap_ovf[ch] == exo, $sformatf("R7 vec%0d overflow", i), 32'(cap_ovf[ch]), 32'(exo));
      check(not_empty[ch] == (exn > 0), $sformatf("R8 vec%0d not_empty", i),
            32'(not_empty[ch]), 32'(exn > 0));
      check(irq[ch] == (exn > 0), $sformatf("R8 vec%0d irq", i), 32'(irq[ch]), 32'(exn > 0));
      n = 0;
      for (int k = 0; k < 4; k++) begin
        if (not_empty[ch]) begin
          pop_one(ch, v);
          n++;
          check(v == expv, $sformatf("R3 vec%0d timestamp", i), 32'(v), 32'(expv));
        end
      end
      check(n == exn, $sformatf("R2/R5 vec%0d entries", i), 32'(n), 32'(exn));
      check(cap_ovf[ch] == 1'b0, $sformatf("R7 vec%0d ovf cleared", i), 32'(cap_ovf[ch]), 0);
    end

    // R4: pulse shorter than the filter window is ignored, longer one is taken
    set_cfg(0, 1, 0, 4, 0);
    tmr_a = 16'h0BAD;
    pulse(0, 2, 10);
    check(not_empty[0] == 1'b0, "R4 short pulse rejected", 32'(not_empty[0]), 0);
    pulse(0, 8, 10);
    check(not_empty[0] == 1'b1, "R4 long pulse accepted", 32'(not_empty[0]), 1);
    pop_one(0, v);
    check(v == 16'h0BAD, "R4 long pulse stamp", 32'(v), 32'h0BAD);

    // R4: zero length acts as one, single-cycle pulse gives both edges
    set_cfg(0, 3, 0, 0, 0);
    pulse(0, 1, 10);
    n = 0;
    for (int k = 0; k < 4; k++) if (not_empty[0]) begin pop_one(0, v); n++; end
    check(n == 2, "R4 one-cycle pulse with zero length", 32'(n), 2);

    // R6: oldest entry first
    set_cfg(1, 1, 0, 1, 0);
    tmr_a = 16'h1111;
    pulse(1, 6, 6);
    tmr_a = 16'h2222;
    pulse(1, 6, 6);
    pop_one(1, v);
    check(v == 16'h1111, "R6 first pop oldest", 32'(v), 32'h1111);
    pop_one(1, v);
    check(v == 16'h2222, "R6 second pop", 32'(v), 32'h2222);
    check(not_empty[1] == 1'b0, "R6 empty after two pops", 32'(not_empty[1]), 0);

    // R8: interrupt mask and channel independence
    set_cfg(2, 1, 0, 1, 1);
    tmr_b = 16'h3333;
    pulse(2, 6, 6);
    irq_en[2] = 1'b0;
    #1;
    check(irq[2] == 1'b0, "R8 masked irq", 32'(irq[2]), 0);
    check(not_empty[2] == 1'b1, "R8 data held while masked", 32'(not_empty[2]), 1);
    irq_en[2] = 1'b1;
    #1;
    check(irq[2] == 1'b1, "R8 unmasked irq", 32'(irq[2]), 1);
    tick(1);
    pop_one(3, v);
    check(v == 16'h0000, "R6 read of empty channel", 32'(v), 0);
    check(not_empty[2] == 1'b1, "R8 other channel untouched", 32'(not_empty[2]), 1);
    pop_one(2, v);
    check(v == 16'h3333, "R3 timer b stamp", 32'(v), 32'h3333);
    check(irq[2] == 1'b0, "R8 irq drops when empty", 32'(irq[2]), 0);

    // R5: divider restarts when the channel is disabled
    set_cfg(3, 1, 1, 1, 0);
    tmr_a = 16'h4444;
    pulse(3, 6, 6);
    check(not_empty[3] == 1'b0, "R5 first of two edges", 32'(not_empty[3]), 0);
    set_cfg(3, 1, 1, 1, 0);
    pulse(3, 6, 6);
    check(not_empty[3] == 1'b0, "R5 count restarted", 32'(not_empty[3]), 0);
    pulse(3, 6, 6);
    check(not_empty[3] == 1'b1, "R5 second edge after restart", 32'(not_empty[3]), 1);
    drain(3);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule